// File: doc/BRIEF.md
# Queue Interrupt Status Aggregator

This block gathers completion and error events from the transmit and receive queue engines of up to fifteen endpoints and turns them into one interrupt request for a processor. Each completion event is held in a done status register. Transmit events occupy the low half of that register and receive events the high half. An enable register of the same layout selects which held bits may raise the interrupt.

Error events follow a two-level scheme. Checksum, length and zero-length-packet errors are first latched per endpoint in three error registers. Each of those registers has its own enable register. An error event whose per-endpoint enable is set also sets one of five bits in an exception summary register. That summary register is cleared by reading it. The per-endpoint registers and the done register are cleared by writing ones. A small register bus gives access to all of it: word address, write strobe, read strobe, and read data one cycle later.

Endpoint 0 is not served by the queue logic. Event inputs are vectors whose element k belongs to endpoint k+1.

Top module: `qint_agg`

## Requirements
- R1: After reset, every register reads zero and `irq` is low.
- R2: A pulse on element k of `tx_done_ev` sets bit k+1 of the done status register (address 0). A pulse on element k of `rx_done_ev` sets bit k+17. Bits 0 and 16 always read zero.
- R3: Writing to the done status register clears exactly the bits written as one. Written zeros leave bits unchanged.
- R4: An event arriving in the same cycle as a write-one clear of its bit leaves that bit set. This holds for the done register and for the error registers.
- R5: The enable registers read back what was written, except bits that map to no endpoint, which read zero. The enable registers are: done enable (address 1, bits 1-15 and 17-31), summary enable (address 3, bits 0-4), receive error enable (address 5), transmit error enable (address 7) and zero-length enable (address 9, bits 1-15).
- R6: The receive error register (address 4) and the transmit error register (address 6) hold checksum errors at bit k+1 and length errors at bit k+17. The zero-length error register (address 8) holds receive zero-length errors at bit k+1. All three are cleared by writing ones, and they latch events whatever their enable holds.
- R7: Summary bits (address 2) are assigned as follows: bit 0 receive checksum, bit 1 receive length, bit 2 receive zero-length, bit 3 transmit checksum, bit 4 transmit length. A bit is set only by an error event whose bit in the matching error enable register is one.
- R8: A read of the summary register returns its contents and then clears it. An enabled error event in the same cycle as the read leaves its bit set.
- R9: `irq` is high one cycle after any done bit is set together with its done enable bit, or any summary bit is set together with its summary enable bit. Otherwise `irq` is low.
- R10: Read data appears on the cycle after the read strobe. Unmapped addresses read zero. Writes to the summary register have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_done_ev | input | EP_CNT | Transmit queue done pulses, element k = endpoint k+1 |
| rx_done_ev | input | EP_CNT | Receive queue done pulses |
| tx_cs_err_ev | input | EP_CNT | Transmit checksum error pulses |
| tx_len_err_ev | input | EP_CNT | Transmit length error pulses |
| rx_cs_err_ev | input | EP_CNT | Receive checksum error pulses |
| rx_len_err_ev | input | EP_CNT | Receive length error pulses |
| rx_zlp_err_ev | input | EP_CNT | Receive zero-length-packet error pulses |
| bus_addr | input | 4 | Word address |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid one cycle after `bus_re` |
| irq | output | 1 | Registered interrupt request |

## Verification
The assertions assume that every event input is low while reset is held. They also assume that a write strobe and a read strobe never share a cycle, so a clear-on-read and a write-one clear never meet in one cycle. The bench drives all inputs on the falling edge. It raises each event for exactly one cycle and issues each bus access as a single-cycle strobe, so it stays within those assumptions while still placing events deliberately in the same cycle as clears.

// File: rtl/qint_pkg.sv
package qint_pkg;
  localparam int HALF   = 16;
  localparam int REG_AW = 4;
  localparam int SUM_W  = 5;

  localparam logic [REG_AW-1:0] A_DONE     = 4'd0;
  localparam logic [REG_AW-1:0] A_DONE_EN  = 4'd1;
  localparam logic [REG_AW-1:0] A_SUM      = 4'd2;
  localparam logic [REG_AW-1:0] A_SUM_EN   = 4'd3;
  localparam logic [REG_AW-1:0] A_RXERR    = 4'd4;
  localparam logic [REG_AW-1:0] A_RXERR_EN = 4'd5;
  localparam logic [REG_AW-1:0] A_TXERR    = 4'd6;
  localparam logic [REG_AW-1:0] A_TXERR_EN = 4'd7;
  localparam logic [REG_AW-1:0] A_ZLP      = 4'd8;
  localparam logic [REG_AW-1:0] A_ZLP_EN   = 4'd9;

  // summary bit positions
  localparam int S_RX_CS  = 0;
  localparam int S_RX_LEN = 1;
  localparam int S_RX_ZLP = 2;
  localparam int S_TX_CS  = 3;
  localparam int S_TX_LEN = 4;

  // bits 1..n set: the lanes that belong to a served endpoint
  function automatic logic [HALF-1:0] lane_mask(input int n);
    logic [HALF-1:0] m;
    m = '0;
    for (int i = 1; i <= n && i < HALF; i++) m[i] = 1'b1;
    return m;
  endfunction

  // endpoint-indexed vector (element k = endpoint k+1) to lane layout
  function automatic logic [HALF-1:0] place(input logic [HALF-2:0] ev);
    return {ev, 1'b0};
  endfunction

  function automatic logic [2*HALF-1:0] pair(input logic [HALF-1:0] lo,
                                             input logic [HALF-1:0] hi);
    return {hi, lo};
  endfunction
endpackage

// File: rtl/qint_w1c.sv
module qint_w1c #(
  parameter int              W    = 32,
  parameter logic [W-1:0]    MASK = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set,
  input  logic [W-1:0] clr,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= ((q & ~clr) | set) & MASK;
  end
endmodule

// File: rtl/qint_enreg.sv
module qint_enreg #(
  parameter int              W    = 32,
  parameter logic [W-1:0]    MASK = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (we) q <= d & MASK;
  end
endmodule

// File: rtl/qint_rcsum.sv
module qint_rcsum #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set,
  input  logic         rd_clr,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= (rd_clr ? '0 : q) | set;
  end
endmodule

// File: rtl/qint_agg.sv
module qint_agg
  import qint_pkg::*;
#(
  parameter int EP_CNT = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [EP_CNT-1:0] tx_done_ev,
  input  logic [EP_CNT-1:0] rx_done_ev,
  input  logic [EP_CNT-1:0] tx_cs_err_ev,
  input  logic [EP_CNT-1:0] tx_len_err_ev,
  input  logic [EP_CNT-1:0] rx_cs_err_ev,
  input  logic [EP_CNT-1:0] rx_len_err_ev,
  input  logic [EP_CNT-1:0] rx_zlp_err_ev,
  input  logic [3:0]        bus_addr,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq
);
  localparam int LW = HALF - 1;
  localparam logic [HALF-1:0]   LANES   = lane_mask(EP_CNT);
  localparam logic [2*HALF-1:0] PAIR_M  = {LANES, LANES};
  localparam logic [2*HALF-1:0] ZLP_M   = {{HALF{1'b0}}, LANES};

  // widened event vectors, element k = endpoint k+1
  logic [LW-1:0] w_txd, w_rxd, w_txcs, w_txlen, w_rxcs, w_rxlen, w_rxzlp;
  always_comb begin
    w_txd = '0; w_rxd = '0; w_txcs = '0; w_txlen = '0;
    w_rxcs = '0; w_rxlen = '0; w_rxzlp = '0;
    w_txd[EP_CNT-1:0]   = tx_done_ev;
    w_rxd[EP_CNT-1:0]   = rx_done_ev;
    w_txcs[EP_CNT-1:0]  = tx_cs_err_ev;
    w_txlen[EP_CNT-1:0] = tx_len_err_ev;
    w_rxcs[EP_CNT-1:0]  = rx_cs_err_ev;
    w_rxlen[EP_CNT-1:0] = rx_len_err_ev;
    w_rxzlp[EP_CNT-1:0] = rx_zlp_err_ev;
  end

  // named internal events
  logic [31:0] done_set, done_clr, rxe_set, rxe_clr, txe_set, txe_clr;
  logic [31:0] zlp_set, zlp_clr;
  logic [SUM_W-1:0] sum_set;
  logic        sum_rd_clr;

  logic [31:0] done_q, den_q, rxe_q, rxen_q, txe_q, txen_q, zlp_q, zen_q;
  logic [SUM_W-1:0] sum_q, sen_q;

  function automatic logic [31:0] clr_for(input logic [3:0] a, input logic [3:0] mine,
                                          input logic we, input logic [31:0] d);
    return (we && a == mine) ? d : 32'd0;
  endfunction

  assign done_set = pair(place(w_txd), place(w_rxd));
  assign rxe_set  = pair(place(w_rxcs), place(w_rxlen));
  assign txe_set  = pair(place(w_txcs), place(w_txlen));
  assign zlp_set  = pair(place(w_rxzlp), '0);
  assign done_clr = clr_for(bus_addr, A_DONE,  bus_we, bus_wdata);
  assign rxe_clr  = clr_for(bus_addr, A_RXERR, bus_we, bus_wdata);
  assign txe_clr  = clr_for(bus_addr, A_TXERR, bus_we, bus_wdata);
  assign zlp_clr  = clr_for(bus_addr, A_ZLP,   bus_we, bus_wdata);

  // only enabled per-endpoint errors reach the summary
  always_comb begin
    sum_set           = '0;
    sum_set[S_RX_CS]  = |(place(w_rxcs)  & rxen_q[HALF-1:0]);
    sum_set[S_RX_LEN] = |(place(w_rxlen) & rxen_q[2*HALF-1:HALF]);
    sum_set[S_RX_ZLP] = |(place(w_rxzlp) & zen_q[HALF-1:0]);
    sum_set[S_TX_CS]  = |(place(w_txcs)  & txen_q[HALF-1:0]);
    sum_set[S_TX_LEN] = |(place(w_txlen) & txen_q[2*HALF-1:HALF]);
  end
  assign sum_rd_clr = bus_re && bus_addr == A_SUM;

  qint_w1c #(.W(32), .MASK(PAIR_M)) u_done (.clk(clk), .rst_n(rst_n),
    .set(done_set), .clr(done_clr), .q(done_q));
  qint_w1c #(.W(32), .MASK(PAIR_M)) u_rxe (.clk(clk), .rst_n(rst_n),
    .set(rxe_set), .clr(rxe_clr), .q(rxe_q));
  qint_w1c #(.W(32), .MASK(PAIR_M)) u_txe (.clk(clk), .rst_n(rst_n),
    .set(txe_set), .clr(txe_clr), .q(txe_q));
  qint_w1c #(.W(32), .MASK(ZLP_M)) u_zlp (.clk(clk), .rst_n(rst_n),
    .set(zlp_set), .clr(zlp_clr), .q(zlp_q));

  qint_enreg #(.W(32), .MASK(PAIR_M)) u_den (.clk(clk), .rst_n(rst_n),
    .we(bus_we && bus_addr == A_DONE_EN), .d(bus_wdata), .q(den_q));
  qint_enreg #(.W(32), .MASK(PAIR_M)) u_rxen (.clk(clk), .rst_n(rst_n),
    .we(bus_we && bus_addr == A_RXERR_EN), .d(bus_wdata), .q(rxen_q));
  qint_enreg #(.W(32), .MASK(PAIR_M)) u_txen (.clk(clk), .rst_n(rst_n),
    .we(bus_we && bus_addr == A_TXERR_EN), .d(bus_wdata), .q(txen_q));
  qint_enreg #(.W(32), .MASK(ZLP_M)) u_zen (.clk(clk), .rst_n(rst_n),
    .we(bus_we && bus_addr == A_ZLP_EN), .d(bus_wdata), .q(zen_q));
  qint_enreg #(.W(SUM_W), .MASK('1)) u_sen (.clk(clk), .rst_n(rst_n),
    .we(bus_we && bus_addr == A_SUM_EN), .d(bus_wdata[SUM_W-1:0]), .q(sen_q));

  qint_rcsum #(.W(SUM_W)) u_sum (.clk(clk), .rst_n(rst_n),
    .set(sum_set), .rd_clr(sum_rd_clr), .q(sum_q));

  // read path: one register stage
  logic [31:0] rd_mux;
  always_comb begin
    unique case (bus_addr)
      A_DONE:     rd_mux = done_q;
      A_DONE_EN:  rd_mux = den_q;
      A_SUM:      rd_mux = {{(32-SUM_W){1'b0}}, sum_q};
      A_SUM_EN:   rd_mux = {{(32-SUM_W){1'b0}}, sen_q};
      A_RXERR:    rd_mux = rxe_q;
      A_RXERR_EN: rd_mux = rxen_q;
      A_TXERR:    rd_mux = txe_q;
      A_TXERR_EN: rd_mux = txen_q;
      A_ZLP:      rd_mux = zlp_q;
      A_ZLP_EN:   rd_mux = zen_q;
      default:    rd_mux = 32'd0;
    endcase
  end

  logic irq_d;
  assign irq_d = (|(done_q & den_q)) | (|(sum_q & sen_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata <= '0;
      irq       <= 1'b0;
    end else begin
      bus_rdata <= bus_re ? rd_mux : 32'd0;
      irq       <= irq_d;
    end
  end
endmodule

// File: rtl/qint_agg_chk.sv
module qint_agg_chk #(
  parameter int SUM_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic [31:0]      done_q,
  input logic [31:0]      done_set,
  input logic [31:0]      done_clr,
  input logic [31:0]      den_q,
  input logic [SUM_W-1:0] sum_q,
  input logic [SUM_W-1:0] sum_set,
  input logic             sum_rd_clr,
  input logic             irq
);
  assert_ep0_lanes_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_q[0] || done_q[16]));

  assert_done_fall_needs_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q != 32'd0) |=> ((~done_q & $past(done_q) & ~$past(done_clr)) == 32'd0));

  assert_done_set_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done_set != 32'd0) |=> ((done_q & $past(done_set)) == $past(done_set)));

  assert_sum_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sum_set == '0 && !sum_rd_clr) |=> (sum_q == $past(sum_q)));

  assert_sum_read_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sum_rd_clr && sum_set == '0) |=> (sum_q == '0));

  assert_irq_from_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((done_q & den_q) != 32'd0) |=> irq);
endmodule

bind qint_agg qint_agg_chk #(.SUM_W(qint_pkg::SUM_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .done_q(done_q), .done_set(done_set),
  .done_clr(done_clr), .den_q(den_q), .sum_q(sum_q), .sum_set(sum_set),
  .sum_rd_clr(sum_rd_clr), .irq(irq));

// File: tb/qint_agg_tb.sv
module qint_agg_tb;
  localparam int EP = 15;
  logic clk, rst_n;
  logic [EP-1:0] txd, rxd, txcs, txlen, rxcs, rxlen, rxzlp;
  logic [3:0]  addr;
  logic        we, re;
  logic [31:0] wdata, rdata;
  logic        irq;
  int total = 0, bad = 0;

  qint_agg #(.EP_CNT(EP)) u_dut (.clk(clk), .rst_n(rst_n),
    .tx_done_ev(txd), .rx_done_ev(rxd), .tx_cs_err_ev(txcs), .tx_len_err_ev(txlen),
    .rx_cs_err_ev(rxcs), .rx_len_err_ev(rxlen), .rx_zlp_err_ev(rxzlp),
    .bus_addr(addr), .bus_we(we), .bus_re(re), .bus_wdata(wdata),
    .bus_rdata(rdata), .irq(irq));

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // kind: 0 txd 1 rxd 2 txcs 3 txlen 4 rxcs 5 rxlen 6 rxzlp
  task automatic drive_ev(input int kind, input int idx, input logic v);
    case (kind)
      0: txd[idx] = v;   1: rxd[idx] = v;   2: txcs[idx] = v;
      3: txlen[idx] = v; 4: rxcs[idx] = v;  5: rxlen[idx] = v;
      default: rxzlp[idx] = v;
    endcase
  endtask

  task automatic pulse(input int kind, input int idx);
    @(negedge clk); drive_ev(kind, idx, 1'b1);
    @(negedge clk); drive_ev(kind, idx, 1'b0);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; we = 1'b1; wdata = d;
    @(negedge clk); we = 1'b0; wdata = '0;
  endtask

  task automatic wr_ev(input logic [3:0] a, input logic [31:0] d, input int kind, input int idx);
    @(negedge clk); addr = a; we = 1'b1; wdata = d; drive_ev(kind, idx, 1'b1);
    @(negedge clk); we = 1'b0; wdata = '0; drive_ev(kind, idx, 1'b0);
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; re = 1'b1;
    @(negedge clk); re = 1'b0; d = rdata;
  endtask

  task automatic rd_ev(input logic [3:0] a, output logic [31:0] d, input int kind, input int idx);
    @(negedge clk); addr = a; re = 1'b1; drive_ev(kind, idx, 1'b1);
    @(negedge clk); re = 1'b0; drive_ev(kind, idx, 1'b0); d = rdata;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    for (int a = 0; a < 10; a++) begin rd(4'(a), d); chk("R1 reg", d, 32'd0); end
    chk("R1 irq", {31'd0, irq}, 32'd0);
  endtask

  task automatic t_done_map();
    logic [31:0] d;
    pulse(0, 2); pulse(1, 4); pulse(0, 14); pulse(1, 14);
    rd(4'd0, d); chk("R2 done map", d, 32'h8020_8008);
    wr(4'd0, 32'hFFFF_FFFF); rd(4'd0, d); chk("R3 clear all", d, 32'd0);
  endtask

  task automatic t_w1c();
    logic [31:0] d;
    pulse(0, 0); pulse(0, 1);
    wr(4'd0, 32'h2); rd(4'd0, d); chk("R3 partial clear", d, 32'h4);
    wr(4'd0, 32'h0); rd(4'd0, d); chk("R3 zero write", d, 32'h4);
    wr(4'd0, 32'h4);
  endtask

  task automatic t_collide();
    logic [31:0] d;
    pulse(0, 0);
    wr_ev(4'd0, 32'h2, 0, 0); rd(4'd0, d); chk("R4 done set wins", d, 32'h2);
    wr(4'd0, 32'h2);
    pulse(2, 0);
    wr_ev(4'd6, 32'h2, 2, 0); rd(4'd6, d); chk("R4 err set wins", d, 32'h2);
    wr(4'd6, 32'hFFFF_FFFF);
  endtask

  task automatic t_enables();
    logic [31:0] d;
    wr(4'd1, 32'hFFFF_FFFF); rd(4'd1, d); chk("R5 done en", d, 32'hFFFE_FFFE);
    wr(4'd3, 32'hFFFF_FFFF); rd(4'd3, d); chk("R5 sum en", d, 32'h1F);
    wr(4'd5, 32'hFFFF_FFFF); rd(4'd5, d); chk("R5 rx en", d, 32'hFFFE_FFFE);
    wr(4'd7, 32'hFFFF_FFFF); rd(4'd7, d); chk("R5 tx en", d, 32'hFFFE_FFFE);
    wr(4'd9, 32'hFFFF_FFFF); rd(4'd9, d); chk("R5 zlp en", d, 32'h0000_FFFE);
    wr(4'd2, 32'hFFFF_FFFF); rd(4'd2, d); chk("R10 sum write ignored", d, 32'd0);
    for (int a = 1; a < 10; a += 2) wr(4'(a), 32'd0);
  endtask

  task automatic t_err_regs();
    logic [31:0] d;
    pulse(4, 1); pulse(5, 3);
    rd(4'd4, d); chk("R6 rx err", d, 32'h0010_0004);
    pulse(2, 0); pulse(3, 14);
    rd(4'd6, d); chk("R6 tx err", d, 32'h8000_0002);
    pulse(6, 6);
    rd(4'd8, d); chk("R6 zlp err", d, 32'h80);
    rd(4'd2, d); chk("R7 disabled no summary", d, 32'd0);
    wr(4'd4, 32'hFFFF_FFFF); wr(4'd6, 32'hFFFF_FFFF); wr(4'd8, 32'hFFFF_FFFF);
    rd(4'd4, d); chk("R6 rx cleared", d, 32'd0);
    rd(4'd8, d); chk("R6 zlp cleared", d, 32'd0);
  endtask

  task automatic t_summary();
    logic [31:0] d;
    wr(4'd5, 32'h4);
    pulse(4, 2); rd(4'd2, d); chk("R7 other ep disabled", d, 32'd0);
    pulse(4, 1); rd(4'd2, d); chk("R7 rx cs", d, 32'h1);
    rd(4'd2, d); chk("R8 read clears", d, 32'd0);
    wr(4'd5, 32'hFFFF_FFFF); wr(4'd7, 32'hFFFF_FFFF); wr(4'd9, 32'hFFFF_FFFF);
    pulse(5, 0); pulse(6, 3); pulse(2, 5); pulse(3, 9);
    rd(4'd2, d); chk("R7 four classes", d, 32'h1E);
    rd(4'd2, d); chk("R8 cleared", d, 32'd0);
    rd_ev(4'd2, d, 4, 1); chk("R8 read value", d, 32'd0);
    rd(4'd2, d); chk("R8 set survives read", d, 32'h1);
    rd(4'd12, d); chk("R10 unmapped", d, 32'd0);
  endtask

  task automatic t_irq();
    logic [31:0] d;
    wr(4'd1, 32'd0); pulse(0, 0); @(negedge clk);
    chk("R9 masked done", {31'd0, irq}, 32'd0);
    wr(4'd1, 32'h2); @(negedge clk);
    chk("R9 done irq", {31'd0, irq}, 32'd1);
    wr(4'd0, 32'h2); @(negedge clk);
    chk("R9 done irq drop", {31'd0, irq}, 32'd0);
    wr(4'd3, 32'h1); pulse(4, 1); @(negedge clk);
    chk("R9 summary irq", {31'd0, irq}, 32'd1);
    rd(4'd2, d); @(negedge clk);
    chk("R9 irq after read", {31'd0, irq}, 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    {txd, rxd, txcs, txlen, rxcs, rxlen, rxzlp} = '0;
    addr = '0; we = 1'b0; re = 1'b0; wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_done_map();
    t_w1c();
    t_collide();
    t_enables();
    t_err_regs();
    t_summary();
    t_irq();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule